// File: doc/BRIEF.md
# Transmit Continuation Checker

This block runs beside a serial frame transmitter. It decides, one character at a time, whether the frame goes on after the current character or ends with it. The serializer reports each bit it sends with a one-cycle strobe and the 1-based position of that bit inside its character. The block samples the transmit FIFO's empty flag at one bit position only. That position is one bit before the last bit of the character, and it depends on the character format latched when transmission starts.

If the FIFO holds data at that position, the "accept further data" output stays high and the serializer moves on to the next character. A host can therefore top up the FIFO late and still send a frame longer than the FIFO can hold. If the FIFO is empty at that position, the accept output drops. The current character still completes, and one cycle after its last bit the block raises a one-cycle frame-end pulse and returns to idle.

Top module: `ctx_top`

## Requirements
- R1: Synchronous active-high reset, including a reset in the middle of a frame, drives `accept_o` and `frame_end_o` low and leaves the block idle.
- R2: A `tx_start_i` pulse while idle sets `accept_o` high on the next cycle and latches `fmt_i` and `xlen_i` for the whole frame.
- R3: Format code 2'b00 (8 data bits plus parity, 9 bits per character) checks the FIFO at bit 8; code 2'b11 behaves the same way.
- R4: Format code 2'b01 (8 bits, no parity) checks the FIFO at bit 7 of 8.
- R5: Format code 2'b10 (x bits, no parity) takes x from `xlen_i` (value 0 means 8) and checks at bit x-1. For x = 1 the check is made at bit 1, which is also the last bit of the character.
- R6: If `fifo_empty_i` is low at the check tick, `accept_o` stays high and the frame continues with the next character.
- R7: The value of `fifo_empty_i` at any tick other than the check tick, or in a cycle without `bit_tick_i`, has no effect on `accept_o` or `frame_end_o`.
- R8: If `fifo_empty_i` is high at the check tick, `accept_o` falls on the next cycle. `frame_end_o` is high for exactly one cycle, the cycle after the tick of the character's last bit, and the block then goes idle.
- R9: A `tx_start_i` pulse while a frame is active is ignored: the latched format does not change.
- R10: Bit ticks while idle change neither output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start_i | input | 1 | Start-of-transmission pulse |
| fmt_i | input | 2 | Character format code |
| xlen_i | input | XW | Bits per character in x-bit format (0 means 2**XW) |
| bit_tick_i | input | 1 | One-cycle strobe for each bit sent |
| bit_idx_i | input | IDX_W | 1-based position of the bit just sent, valid with the strobe |
| fifo_empty_i | input | 1 | Transmit FIFO empty flag |
| accept_o | output | 1 | Accept further data, registered |
| frame_end_o | output | 1 | One-cycle frame-end pulse, registered |

## Verification
The assertions assume the serializer behaves: `bit_idx_i` counts 1 up to the character length on successive strobes and restarts at 1 for each new character, and `tx_start_i` never coincides with a strobe. The bench drives ticks only through a task that walks the positions in that order, with idle cycles between strobes, and pulses `tx_start_i` only between strobes. The frame-end property relies on the check position never lying after the last position, which the decoder guarantees for every format and x value.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic [1:0] {
    FMT_PAR8  = 2'b00,
    FMT_RAW8  = 2'b01,
    FMT_XBITS = 2'b10,
    FMT_RSVD  = 2'b11
  } frame_fmt_e;
endpackage

// File: rtl/ctx_pos_decode.sv
module ctx_pos_decode
  import ctx_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int XW    = 3
) (
  input  frame_fmt_e        fmt,
  input  logic [XW-1:0]     xlen,
  output logic [IDX_W-1:0]  last_pos,
  output logic [IDX_W-1:0]  check_pos
);
  localparam logic [IDX_W-1:0] LEN_PAR8 = IDX_W'(9);
  localparam logic [IDX_W-1:0] LEN_RAW8 = IDX_W'(8);
  localparam logic [IDX_W-1:0] LEN_XMAX = IDX_W'(2**XW);
  localparam logic [IDX_W-1:0] ONE      = IDX_W'(1);

  always_comb begin
    unique case (fmt)
      FMT_RAW8:  last_pos = LEN_RAW8;
      FMT_XBITS: last_pos = (xlen == '0) ? LEN_XMAX : IDX_W'(xlen);
      default:   last_pos = LEN_PAR8;
    endcase
    check_pos = (last_pos > ONE) ? last_pos - ONE : ONE;
  end
endmodule

// File: rtl/ctx_ctrl.sv
module ctx_ctrl #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tick,
  input  logic [IDX_W-1:0] idx,
  input  logic             empty,
  input  logic [IDX_W-1:0] check_pos,
  input  logic [IDX_W-1:0] last_pos,
  output logic             active,
  output logic             accept,
  output logic             frame_end
);
  logic at_check, at_last, drop;

  assign at_check = tick & active & (idx == check_pos);
  assign at_last  = tick & active & (idx == last_pos);
  assign drop     = at_check & empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      accept    <= 1'b0;
      frame_end <= 1'b0;
    end else begin
      frame_end <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          accept <= 1'b1;
        end
      end else begin
        if (drop) accept <= 1'b0;
        if (at_last && (!accept || drop)) begin
          active    <= 1'b0;
          frame_end <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ctx_top.sv
module ctx_top
  import ctx_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int XW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_start_i,
  input  logic [1:0]       fmt_i,
  input  logic [XW-1:0]    xlen_i,
  input  logic             bit_tick_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             fifo_empty_i,
  output logic             accept_o,
  output logic             frame_end_o
);
  frame_fmt_e       fmt_q;
  logic [XW-1:0]    xlen_q;
  logic [IDX_W-1:0] last_pos, check_pos;
  logic             active;

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q  <= FMT_PAR8;
      xlen_q <= '0;
    end else if (tx_start_i && !active) begin
      fmt_q  <= frame_fmt_e'(fmt_i);
      xlen_q <= xlen_i;
    end
  end

  ctx_pos_decode #(.IDX_W(IDX_W), .XW(XW)) u_dec (
    .fmt       (fmt_q),
    .xlen      (xlen_q),
    .last_pos  (last_pos),
    .check_pos (check_pos)
  );

  ctx_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (tx_start_i),
    .tick      (bit_tick_i),
    .idx       (bit_idx_i),
    .empty     (fifo_empty_i),
    .check_pos (check_pos),
    .last_pos  (last_pos),
    .active    (active),
    .accept    (accept_o),
    .frame_end (frame_end_o)
  );
endmodule

// File: rtl/ctx_top_chk.sv
module ctx_top_chk (
  input logic clk,
  input logic rst,
  input logic tx_start_i,
  input logic bit_tick_i,
  input logic fifo_empty_i,
  input logic accept_o,
  input logic frame_end_o
);
  a_r8_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    frame_end_o |=> !frame_end_o);

  a_r8_end_after_tick: assert property (@(posedge clk) disable iff (rst)
    frame_end_o |-> $past(bit_tick_i));

  a_r8_end_without_accept: assert property (@(posedge clk) disable iff (rst)
    frame_end_o |-> !accept_o);

  a_r7_drop_needs_empty_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(accept_o) |-> $past(bit_tick_i && fifo_empty_i));

  a_r2_rise_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(accept_o) |-> $past(tx_start_i));
endmodule

bind ctx_top ctx_top_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .tx_start_i   (tx_start_i),
  .bit_tick_i   (bit_tick_i),
  .fifo_empty_i (fifo_empty_i),
  .accept_o     (accept_o),
  .frame_end_o  (frame_end_o)
);

// File: tb/test_ctx_top.sv
module test_ctx_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 4;
  localparam int XW    = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tx_start_i = 1'b0;
  logic [1:0]       fmt_i = 2'b00;
  logic [XW-1:0]    xlen_i = '0;
  logic             bit_tick_i = 1'b0;
  logic [IDX_W-1:0] bit_idx_i = '0;
  logic             fifo_empty_i = 1'b1;
  logic             accept_o, frame_end_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_top #(.IDX_W(IDX_W), .XW(XW)) i_ctx_top (
    .clk(clk), .rst(rst), .tx_start_i(tx_start_i), .fmt_i(fmt_i), .xlen_i(xlen_i),
    .bit_tick_i(bit_tick_i), .bit_idx_i(bit_idx_i), .fifo_empty_i(fifo_empty_i),
    .accept_o(accept_o), .frame_end_o(frame_end_o)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] f, input logic [2:0] x);
    if (f == 2'b01) return 8;
    if (f == 2'b10) return (x == 0) ? 8 : int'(x);
    return 9;
  endfunction

  function automatic int chk_of(input int len);
    return (len > 1) ? len - 1 : 1;
  endfunction

  task automatic tick(input int idx, input logic empty);
    @(negedge clk);
    bit_tick_i   = 1'b1;
    bit_idx_i    = IDX_W'(idx);
    fifo_empty_i = empty;
    @(negedge clk);
    bit_tick_i   = 1'b0;
    fifo_empty_i = 1'b1;
  endtask

  task automatic start(input logic [1:0] f, input logic [2:0] x, input string req);
    @(negedge clk);
    tx_start_i = 1'b1; fmt_i = f; xlen_i = x;
    @(negedge clk);
    tx_start_i = 1'b0;
    check(req, "accept after start", accept_o, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  // FIFO empty at every tick except the check ticks of continuing characters.
  task automatic run_frame(input logic [1:0] f, input logic [2:0] x, input int nchars, input string req);
    int len = len_of(f, x);
    int cp  = chk_of(len);
    logic exp_acc = 1'b1;
    start(f, x, "R2");
    for (int c = 1; c <= nchars; c++) begin
      for (int i = 1; i <= len; i++) begin
        logic last_char = (c == nchars);
        tick(i, (i == cp) ? last_char : 1'b1);
        if (i == cp && last_char) exp_acc = 1'b0;
        check(req, $sformatf("accept c%0d bit%0d", c, i), accept_o, exp_acc);
        check((i == len && last_char) ? "R8" : "R7",
              $sformatf("frame_end c%0d bit%0d", c, i), frame_end_o, (i == len && last_char));
      end
    end
    @(negedge clk);
    check("R8", "frame_end single cycle", frame_end_o, 1'b0);
  endtask

  task automatic t_reset();
    check("R1", "accept at reset", accept_o, 1'b0);
    check("R1", "frame_end at reset", frame_end_o, 1'b0);
  endtask

  task automatic t_par8();   run_frame(2'b00, 3'd0, 2, "R3"); endtask
  task automatic t_rsvd();   run_frame(2'b11, 3'd0, 1, "R3"); endtask
  task automatic t_raw8();   run_frame(2'b01, 3'd0, 3, "R4"); endtask
  task automatic t_x5();     run_frame(2'b10, 3'd5, 2, "R5"); endtask
  task automatic t_x8();     run_frame(2'b10, 3'd0, 1, "R5"); endtask
  task automatic t_x1();     run_frame(2'b10, 3'd1, 3, "R5"); endtask
  task automatic t_x2();     run_frame(2'b10, 3'd2, 2, "R6"); endtask

  task automatic t_start_busy();
    start(2'b01, 3'd0, "R2");
    for (int i = 1; i <= 3; i++) tick(i, 1'b1);
    @(negedge clk); tx_start_i = 1'b1; fmt_i = 2'b10; xlen_i = 3'd5;
    @(negedge clk); tx_start_i = 1'b0;
    tick(4, 1'b1);
    check("R9", "accept after ignored start, bit4", accept_o, 1'b1);
    for (int i = 5; i <= 6; i++) tick(i, 1'b1);
    check("R9", "accept before bit7", accept_o, 1'b1);
    tick(7, 1'b1);
    check("R9", "accept drops at bit7", accept_o, 1'b0);
    tick(8, 1'b1);
    check("R9", "frame_end after bit8", frame_end_o, 1'b1);
  endtask

  task automatic t_idle_ticks();
    for (int i = 1; i <= 9; i++) begin
      tick(i, 1'b1);
      check("R10", $sformatf("accept idle bit%0d", i), accept_o, 1'b0);
      check("R10", $sformatf("frame_end idle bit%0d", i), frame_end_o, 1'b0);
    end
  endtask

  task automatic t_mid_reset();
    start(2'b00, 3'd0, "R2");
    tick(1, 1'b0);
    do_reset();
    check("R1", "accept after mid-frame reset", accept_o, 1'b0);
    check("R1", "frame_end after mid-frame reset", frame_end_o, 1'b0);
    for (int i = 1; i <= 9; i++) tick(i, 1'b1);
    check("R1", "idle after reset, no frame_end", frame_end_o, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_par8();
    t_rsvd();
    t_raw8();
    t_x5();
    t_x8();
    t_x1();
    t_x2();
    t_idle_ticks();
    t_start_busy();
    t_mid_reset();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule